// File: doc/BRIEF.md
# Hardware Return Address Stack

This block keeps the return addresses of a small processor in a fixed-depth last-in, first-out store. One architectural register is tied to it. The register-file port logic turns every read of that register into a pop and every write into a push, and it drives the matching enables and write data. The popped address comes back as the read data.

A read and a write in the same access form a swap. The pop is ordered before the push, so the top entry is returned and then replaced. A swap is therefore legal on a full stack, as long as the stack holds at least one entry. Reading an empty stack is an underflow error. Writing a full stack without a pop in the same cycle is an overflow error. An erroring access leaves the stack untouched. A clear input empties the stack when an operation starts or when internal state is wiped.

All outputs are registered. An access sampled at one rising edge shows its read data and error in the cycle that follows. The storage is a simple write port plus a read-first synchronous read port, so it maps onto block RAM.

Top module: `ras_stack`

## Requirements
- R1: The stack holds at most DEPTH entries (default 8) of DW bits (default 32). `empty` is high exactly when no entry is stored and `full` exactly when DEPTH entries are stored. Both reflect every access of the previous cycle.
- R2: A write without a read (`wr_en`=1, `rd_en`=0) on a stack that is not full stores `wr_data` as the new top and raises the depth by one, with `err` low in the following cycle.
- R3: A read without a write on a non-empty stack returns the current top on `rd_data` in the following cycle and lowers the depth by one. Entries come back in last-in, first-out order.
- R4: A read on an empty stack pulses `err` high for the following cycle and sets `rd_data` to zero. The stack stays empty.
- R5: A write without a read on a full stack pulses `err` high for the following cycle. The depth and all stored entries stay unchanged.
- R6: A read and a write together on a stack with at least one entry return the old top on `rd_data`, replace the top with `wr_data`, keep the depth, and leave `err` low, also when the stack is full.
- R7: A read and a write together on an empty stack are an underflow. `err` pulses, `rd_data` becomes zero, and nothing is pushed, so the stack stays empty.
- R8: `clear` empties the stack, forces `err` and `rd_data` to zero in the next cycle, and takes priority over any read or write in the same cycle.
- R9: `rd_data` holds its value through cycles without a read access. `err` is low after any cycle that had neither an error nor a read or write.
- R10: After synchronous reset (`rst` high), the stack is empty, not full, and `err` and `rd_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Empties the stack; wins over accesses |
| rd_en | input | 1 | Read of the tied register (pop) |
| wr_en | input | 1 | Write of the tied register (push) |
| wr_data | input | DW | Return address to push |
| rd_data | output | DW | Popped address, zero after underflow or clear |
| err | output | 1 | One-cycle call-stack error pulse |
| full | output | 1 | DEPTH entries stored |
| empty | output | 1 | No entry stored |

## Verification
The hardest situation to reach from the ports is a swap or an overflowing push while the stack sits exactly at DEPTH. Uniform random enables keep the depth near the middle. The stimulus therefore runs random phases with a strong push bias that pin the stack at full, and phases with a strong pop bias that pin it at empty, where combined accesses hit the underflow rule. Directed sequences then fill the stack, overflow it, swap on full, drain it in LIFO order, and issue clear together with accesses.

// File: rtl/ras_pkg.sv
package ras_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_SWAP = 2'd3
  } ras_op_e;

  function automatic ras_op_e decode_op(input logic rd, input logic wr);
    ras_op_e op;
    unique case ({rd, wr})
      2'b01:   op = OP_PUSH;
      2'b10:   op = OP_POP;
      2'b11:   op = OP_SWAP;
      default: op = OP_IDLE;
    endcase
    return op;
  endfunction

endpackage

// File: rtl/ras_mem.sv
module ras_mem #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  input  logic          q_clr,
  output logic [DW-1:0] q
);

  logic [DW-1:0] ram [DEPTH];

  // Write port
  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
  end

  // Read-first output register with synchronous clear
  always_ff @(posedge clk) begin
    if (q_clr)   q <= '0;
    else if (re) q <= ram[raddr];
  end

endmodule

// File: rtl/ras_ctrl.sv
module ras_ctrl
  import ras_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          rd_en,
  input  logic          wr_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic          mem_re,
  output logic [AW-1:0] mem_raddr,
  output logic          q_clr,
  output logic          err,
  output logic          full,
  output logic          empty
);

  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

  ras_op_e       op;
  logic [CW-1:0] cnt, cnt_nxt;
  logic [AW-1:0] top_idx, free_idx;
  logic          can_pop, can_push, err_d, underflow;

  assign op       = decode_op(rd_en, wr_en);
  assign can_pop  = (cnt != '0);
  assign can_push = (cnt != CNT_MAX);
  assign top_idx  = AW'(cnt - 1'b1);
  assign free_idx = AW'(cnt);

  always_comb begin
    cnt_nxt   = cnt;
    err_d     = 1'b0;
    mem_we    = 1'b0;
    mem_waddr = free_idx;
    mem_re    = 1'b0;
    underflow = 1'b0;
    unique case (op)
      OP_PUSH: begin
        if (can_push) begin
          mem_we  = 1'b1;
          cnt_nxt = cnt + 1'b1;
        end else begin
          err_d = 1'b1;
        end
      end
      OP_POP: begin
        if (can_pop) begin
          mem_re  = 1'b1;
          cnt_nxt = cnt - 1'b1;
        end else begin
          err_d     = 1'b1;
          underflow = 1'b1;
        end
      end
      OP_SWAP: begin
        // pop ordered before push: top is read, then overwritten
        if (can_pop) begin
          mem_re    = 1'b1;
          mem_we    = 1'b1;
          mem_waddr = top_idx;
        end else begin
          err_d     = 1'b1;
          underflow = 1'b1;
        end
      end
      default: ;
    endcase
    if (clear) begin
      cnt_nxt = '0;
      err_d   = 1'b0;
      mem_we  = 1'b0;
      mem_re  = 1'b0;
    end
  end

  assign mem_raddr = top_idx;
  assign q_clr     = rst | clear | underflow;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      err <= 1'b0;
    end else begin
      cnt <= cnt_nxt;
      err <= err_d;
    end
  end

  assign full  = (cnt == CNT_MAX);
  assign empty = (cnt == '0);

  // R1: depth never leaves its legal range
  p_count_bound_r1: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_MAX);

  // R4, R7: any read on an empty stack flags an error
  p_underflow_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty && !clear) |=> (err && empty));

  // R5: lone push on a full stack flags an error and keeps depth
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_en && full && !clear) |=> (err && full));

  // R6: swap on full stack is legal and keeps it full
  p_swap_full_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && wr_en && full && !clear) |=> (!err && full));

  // R4, R5: an erroring access leaves the depth unchanged
  p_err_hold_r5: assert property (@(posedge clk) disable iff (rst)
    err |-> (cnt == $past(cnt)));

  // R8: clear empties the stack and suppresses errors
  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    clear |=> (empty && !err));

  // R1: full and empty are never both set
  p_flags_r1: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

endmodule

// File: rtl/ras_stack.sv
module ras_stack #(
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          err,
  output logic          full,
  output logic          empty
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic          mem_we, mem_re, q_clr;
  logic [AW-1:0] mem_waddr, mem_raddr;

  ras_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .clear     (clear),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_re    (mem_re),
    .mem_raddr (mem_raddr),
    .q_clr     (q_clr),
    .err       (err),
    .full      (full),
    .empty     (empty)
  );

  ras_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (wr_data),
    .re    (mem_re),
    .raddr (mem_raddr),
    .q_clr (q_clr),
    .q     (rd_data)
  );

  // R9: read data only moves on a read, clear or reset
  p_rd_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!rd_en && !clear) |=> $stable(rd_data));

  // R4: underflow returns zero
  p_underflow_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty) |=> (rd_data == '0));

endmodule

// File: tb/tb_ras_stack.sv
module tb_ras_stack;

  localparam int DW      = 32;
  localparam int DEPTH   = 8;
  localparam int CLK_PER = 10;
  localparam int WDOG    = 100000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clear = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          err, full, empty;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  // reference model state
  logic [DW-1:0] m_stk [DEPTH];
  int            m_cnt = 0;
  logic [DW-1:0] m_rd  = '0;
  logic          m_err = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  ras_stack #(.DW(DW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .clear(clear), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .err(err), .full(full), .empty(empty)
  );

  function automatic string req_tag(input bit c, input bit r, input bit w, input int n);
    if (c)                return "R8";
    if (r && w && n == 0) return "R7";
    if (r && w)           return "R6";
    if (r && n == 0)      return "R4";
    if (r)                return "R3";
    if (w && n == DEPTH)  return "R5";
    if (w)                return "R2";
    return "R9";
  endfunction

  function automatic logic exp_err(input bit c, input bit r, input bit w, input int n);
    if (c) return 1'b0;
    if (r) return (n == 0);
    if (w) return (n == DEPTH);
    return 1'b0;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check(tag, "rd_data", rd_data, m_rd);
    check(tag, "err", DW'(err), DW'(m_err));
    check("R1", "full", DW'(full), DW'(m_cnt == DEPTH));
    check("R1", "empty", DW'(empty), DW'(m_cnt == 0));
  endtask

  // drive at negedge, let one posedge pass, check at next negedge
  task automatic step(input bit c, input bit r, input bit w, input logic [DW-1:0] d);
    string tag;
    tag = req_tag(c, r, w, m_cnt);
    clear = c; rd_en = r; wr_en = w; wr_data = d;
    m_err = exp_err(c, r, w, m_cnt);
    if (c) begin
      m_cnt = 0; m_rd = '0;
    end else if (r) begin
      if (m_cnt == 0) m_rd = '0;
      else begin
        m_rd = m_stk[m_cnt-1];
        if (w) m_stk[m_cnt-1] = d;
        else   m_cnt--;
      end
    end else if (w && m_cnt < DEPTH) begin
      m_stk[m_cnt] = d;
      m_cnt++;
    end
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    int dummy;
    dummy = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    check("R10", "rd_data", rd_data, '0);
    check("R10", "err", DW'(err), 32'd0);
    check("R10", "empty", DW'(empty), 32'd1);
    check("R10", "full", DW'(full), 32'd0);

    // R4: pop on empty; R7: swap on empty pushes nothing
    step(0, 1, 0, '0);
    step(0, 1, 1, 32'hDEAD_0001);
    step(0, 0, 0, '0);
    // R2: fill to DEPTH
    for (int i = 0; i < DEPTH; i++) step(0, 0, 1, 32'h1000_0000 + i);
    // R5: overflow twice in a row, contents untouched
    step(0, 0, 1, 32'hBAD0_0000);
    step(0, 0, 1, 32'hBAD0_0001);
    // R6: swap on full
    step(0, 1, 1, 32'hA5A5_0007);
    step(0, 1, 1, 32'hA5A5_0008);
    // R9: idle holds rd_data
    step(0, 0, 0, '0);
    step(0, 0, 1, 32'h0);
    step(0, 1, 0, '0);
    // R3: drain in LIFO order
    for (int i = 0; i < DEPTH; i++) step(0, 1, 0, '0);
    step(0, 1, 0, '0);
    // R8: clear wins over accesses
    for (int i = 0; i < 3; i++) step(0, 0, 1, 32'h2000_0000 + i);
    step(1, 1, 1, 32'hFFFF_FFFF);
    step(0, 1, 0, '0);
    step(0, 0, 1, 32'h3000_0000);
    step(1, 0, 1, 32'h3000_0001);
    step(0, 0, 0, '0);

    // random phases: bias toward full or toward empty
    for (int ph = 0; ph < 30; ph++) begin
      int bias;
      bias = (ph % 3 == 0) ? 85 : ((ph % 3 == 1) ? 15 : 50);
      for (int k = 0; k < 150; k++) begin
        bit c, r, w;
        c = ($urandom_range(99) < 2);
        w = ($urandom_range(99) < bias);
        r = ($urandom_range(99) < (100 - bias));
        step(c, r, w, $urandom());
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int cyc = 0; cyc < WDOG; cyc++) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule